// File: doc/BRIEF.md
# Machine Interrupt Status Register Unit

This unit holds three machine-level registers of a small 32-bit core: the status word, the interrupt-enable word and the interrupt-pending word. Software reaches them through a single-cycle register port. The port has an address, write data, a write strobe and combinational read data. The pipeline drives two one-cycle strobes, one for trap entry and one for return from trap. These strobes save and restore the global interrupt enable.

The unit registers a 32-bit interrupt request vector once per cycle into the pending word. It drives two outputs. One is the global enable. The other is a request flag, raised when the global enable is set and at least one pending line is also enabled.

Two parameters control the floating-point state field and its dirty summary bit. The field is visible only when a floating-point unit is present and that unit keeps its own register file. In every other build, both read as zero.

Top module: `mirq_csr_unit`

## Requirements
- R1: After reset the status word reads 0x0000_1800 (previous-privilege bits 12:11 = 11, all else 0), the enable word reads 0, `gie_o` is 0 and `irq_req_o` is 0.
- R2: In the status word, software writes change only the global enable (bit 3) and the floating-point state field (bits 14:13). Bits 12:11 always read 11. Bits 30:15, 10:8, 6:4 and 2:0 always read 0. Bit 7 is not altered by a write.
- R3: Status bit 31 reads 1 exactly when bits 14:13 hold 11 (dirty).
- R4: When `HAS_FPU` is 0, or `HAS_FPU` is 1 and `FP_IN_INT_REGS` is 1, status bits 14:13 and 31 read 0 whatever is written.
- R5: In the enable word (address `ADDR_ENABLE`, default 0x304), only bits 3, 7, 11 and 31:16 store written values. Every other bit reads 0.
- R6: The pending word (address `ADDR_PENDING`, default 0x344) reads `irq_i` as sampled at the previous rising edge, masked to bits 3, 7, 11 and 31:16. Writes to it have no effect.
- R7: A trap-entry strobe copies the global enable into bit 7 and clears the global enable, both taking effect at the next edge.
- R8: A return-from-trap strobe without trap entry copies bit 7 into the global enable and sets bit 7 to 1.
- R9: `irq_req_o` is 1 exactly when the global enable is 1 and the AND of the pending and enable words is nonzero. `gie_o` mirrors status bit 3.
- R10: A status write in the same cycle as a trap-entry or return strobe is discarded entirely, including its floating-point state bits.
- R11: Addresses other than status (`ADDR_STATUS`, default 0x300), enable and pending read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_we_i | input | 1 | Write strobe |
| csr_rdata_o | output | 32 | Read data for `csr_addr_i` (combinational) |
| irq_i | input | 32 | Interrupt request lines |
| trap_enter_i | input | 1 | Trap-entry strobe |
| trap_return_i | input | 1 | Return-from-trap strobe |
| gie_o | output | 1 | Global interrupt enable |
| irq_req_o | output | 1 | Pending-and-enabled interrupt flag |

## Verification
The bench builds two copies side by side, fed from the same stimulus. The first uses `HAS_FPU`=1 and `FP_IN_INT_REGS`=0, so the floating-point state field and its dirty summary can be written and read back. The second sets `FP_IN_INT_REGS`=1, which exposes the forced-zero path of R4. With both copies, one all-ones write shows which bits each parameter set lets through. Addresses stay at their defaults.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    localparam int unsigned XLEN = 32;
    localparam int unsigned AW   = 12;

    // Lines that exist in both the enable and the pending word
    localparam logic [XLEN-1:0] LINE_MASK = 32'hFFFF_0888;

    localparam int unsigned GIE_BIT  = 3;
    localparam int unsigned PGIE_BIT = 7;
    localparam int unsigned PRIV_LO  = 11;
    localparam int unsigned FPS_LO   = 13;
    localparam int unsigned DIRTY_BIT = XLEN - 1;

    // Bits of the status word that must never read 1 (bit 31 and 14:13 excluded)
    localparam logic [XLEN-1:0] STATUS_ZERO_MASK = 32'h7FFF_8777;

    typedef struct packed {
        logic       gie;
        logic       pgie;
        logic [1:0] fps;
    } stat_t;

    typedef struct packed {
        logic [XLEN-1:0] en;
        logic [XLEN-1:0] pend;
    } lines_t;

endpackage

// File: rtl/mirq_status_reg.sv
module mirq_status_reg
    import mirq_pkg::*;
#(
    parameter bit FP_VISIBLE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic            wr_gie_i,
    input  logic [1:0]      wr_fps_i,
    input  logic            trap_enter_i,
    input  logic            trap_return_i,
    output logic            gie_o,
    output logic [XLEN-1:0] image_o
);

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trap_enter_i) begin
            st_d.pgie = st_q.gie;
            st_d.gie  = 1'b0;
        end else if (trap_return_i) begin
            st_d.gie  = st_q.pgie;
            st_d.pgie = 1'b1;
        end else if (wr_i) begin
            st_d.gie = wr_gie_i;
            st_d.fps = FP_VISIBLE ? wr_fps_i : 2'b00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [1:0] fps_view;
    logic       dirty_view;

    generate
        if (FP_VISIBLE) begin : g_fp_on
            assign fps_view   = st_q.fps;
            assign dirty_view = (st_q.fps == 2'b11);
        end else begin : g_fp_off
            assign fps_view   = 2'b00;
            assign dirty_view = 1'b0;
        end
    endgenerate

    always_comb begin
        image_o                   = '0;
        image_o[GIE_BIT]          = st_q.gie;
        image_o[PGIE_BIT]         = st_q.pgie;
        image_o[PRIV_LO +: 2]     = 2'b11;
        image_o[FPS_LO +: 2]      = fps_view;
        image_o[DIRTY_BIT]        = dirty_view;
    end

    assign gie_o = st_q.gie;

    // R7: trap entry clears the enable and saves it into bit 7
    assert_trap_saves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_enter_i |=> (!gie_o && image_o[PGIE_BIT] == $past(gie_o)));

    // R8: return restores the enable and sets bit 7
    assert_return_restores_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_return_i && !trap_enter_i) |=> (image_o[PGIE_BIT] && gie_o == $past(image_o[PGIE_BIT])));

    // R10: a write alongside a pipeline strobe leaves the FP field untouched
    assert_event_beats_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_enter_i || trap_return_i) |=> $stable(image_o[FPS_LO +: 2]));

endmodule

// File: rtl/mirq_line_regs.sv
module mirq_line_regs
    import mirq_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_wr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [XLEN-1:0] irq_i,
    output logic [XLEN-1:0] en_o,
    output logic [XLEN-1:0] pend_o
);

    lines_t ln_d, ln_q;

    always_comb begin
        ln_d      = ln_q;
        ln_d.pend = irq_i & LINE_MASK;
        if (en_wr_i) begin
            ln_d.en = wdata_i & LINE_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign en_o   = ln_q.en;
    assign pend_o = ln_q.pend;

    // R6: pending follows the request lines of the previous edge
    assert_pend_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (pend_o == ($past(irq_i) & LINE_MASK)));

    // R5: a write without strobe leaves the enable word alone
    assert_en_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_wr_i |=> $stable(en_o));

endmodule

// File: rtl/mirq_read_mux.sv
module mirq_read_mux
    import mirq_pkg::*;
#(
    parameter logic [AW-1:0] ADDR_STATUS  = 12'h300,
    parameter logic [AW-1:0] ADDR_ENABLE  = 12'h304,
    parameter logic [AW-1:0] ADDR_PENDING = 12'h344
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] pend_i,
    output logic [XLEN-1:0] rdata_o
);

    always_comb begin
        case (addr_i)
            ADDR_STATUS:  rdata_o = status_i;
            ADDR_ENABLE:  rdata_o = en_i;
            ADDR_PENDING: rdata_o = pend_i;
            default:      rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/mirq_csr_unit.sv
module mirq_csr_unit
    import mirq_pkg::*;
#(
    parameter bit            HAS_FPU        = 1'b1,
    parameter bit            FP_IN_INT_REGS = 1'b0,
    parameter logic [11:0]   ADDR_STATUS    = 12'h300,
    parameter logic [11:0]   ADDR_ENABLE    = 12'h304,
    parameter logic [11:0]   ADDR_PENDING   = 12'h344
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    input  logic        csr_we_i,
    output logic [31:0] csr_rdata_o,
    input  logic [31:0] irq_i,
    input  logic        trap_enter_i,
    input  logic        trap_return_i,
    output logic        gie_o,
    output logic        irq_req_o
);

    localparam bit FP_VISIBLE = HAS_FPU && !FP_IN_INT_REGS;

    logic            status_wr, en_wr;
    logic [XLEN-1:0] status_img, en_w, pend_w;

    assign status_wr = csr_we_i && (csr_addr_i == ADDR_STATUS);
    assign en_wr     = csr_we_i && (csr_addr_i == ADDR_ENABLE);

    mirq_status_reg #(
        .FP_VISIBLE (FP_VISIBLE)
    ) u_status (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_i          (status_wr),
        .wr_gie_i      (csr_wdata_i[GIE_BIT]),
        .wr_fps_i      (csr_wdata_i[FPS_LO +: 2]),
        .trap_enter_i  (trap_enter_i),
        .trap_return_i (trap_return_i),
        .gie_o         (gie_o),
        .image_o       (status_img)
    );

    mirq_line_regs u_lines (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_wr_i (en_wr),
        .wdata_i (csr_wdata_i),
        .irq_i   (irq_i),
        .en_o    (en_w),
        .pend_o  (pend_w)
    );

    mirq_read_mux #(
        .ADDR_STATUS  (ADDR_STATUS),
        .ADDR_ENABLE  (ADDR_ENABLE),
        .ADDR_PENDING (ADDR_PENDING)
    ) u_rmux (
        .addr_i   (csr_addr_i),
        .status_i (status_img),
        .en_i     (en_w),
        .pend_i   (pend_w),
        .rdata_o  (csr_rdata_o)
    );

    assign irq_req_o = gie_o && |(pend_w & en_w);

    // R9: a request is never raised while the global enable is low
    assert_req_needs_gie_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o |-> gie_o);

    // R2: reserved status bits and the privilege pair keep their fixed values
    assert_status_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == ADDR_STATUS) |->
            (((csr_rdata_o & STATUS_ZERO_MASK) == '0) && (csr_rdata_o[PRIV_LO +: 2] == 2'b11)));

    // R3: dirty summary bit agrees with the state field as read out
    assert_dirty_summary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == ADDR_STATUS) |->
            (csr_rdata_o[DIRTY_BIT] == (csr_rdata_o[FPS_LO +: 2] == 2'b11)));

    // R4: hidden floating-point state reads zero
    generate
        if (!FP_VISIBLE) begin : g_fp_hidden_chk
            assert_fp_hidden_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (csr_addr_i == ADDR_STATUS) |->
                    (csr_rdata_o[DIRTY_BIT] == 1'b0 && csr_rdata_o[FPS_LO +: 2] == 2'b00));
        end
    endgenerate

endmodule

// File: tb/mirq_csr_unit_bench.sv
module mirq_csr_unit_bench;

    localparam logic [11:0] A_ST = 12'h300;
    localparam logic [11:0] A_EN = 12'h304;
    localparam logic [11:0] A_PD = 12'h344;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] irq = '0;
    logic        tenter = 1'b0;
    logic        tret = 1'b0;
    logic [31:0] rdata, rdata_nf;
    logic        gie, req, gie_nf, req_nf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mirq_csr_unit #(.HAS_FPU(1'b1), .FP_IN_INT_REGS(1'b0)) u_mirq_csr_unit (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .csr_rdata_o(rdata), .irq_i(irq), .trap_enter_i(tenter),
        .trap_return_i(tret), .gie_o(gie), .irq_req_o(req)
    );

    mirq_csr_unit #(.HAS_FPU(1'b1), .FP_IN_INT_REGS(1'b1)) u_mirq_csr_unit_nofp (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .csr_rdata_o(rdata_nf), .irq_i(irq), .trap_enter_i(tenter),
        .trap_return_i(tret), .gie_o(gie_nf), .irq_req_o(req_nf)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] dnf);
        addr = a;
        #1;
        d = rdata;
        dnf = rdata_nf;
    endtask

    task automatic pulse(input bit enter, input bit ret);
        @(negedge clk);
        tenter = enter; tret = ret;
        @(negedge clk);
        tenter = 1'b0; tret = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v, vn;
        rd(A_ST, v, vn);
        check("R1 status", v, 32'h0000_1800);
        check("R1 status nofp", vn, 32'h0000_1800);
        rd(A_EN, v, vn);
        check("R1 enable", v, 32'h0);
        check("R1 gie/req", {30'd0, gie, req}, 32'h0);
    endtask

    task automatic t_status_write;
        logic [31:0] v, vn;
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v, vn);
        check("R2 all-ones status", v, 32'h8000_7808);
        check("R9 gie mirrors bit3", {31'd0, gie}, 32'h1);
        check("R4 nofp all-ones status", vn, 32'h0000_1808);
        wr(A_ST, 32'h0000_2000);
        rd(A_ST, v, vn);
        check("R3 fs=01 not dirty", v, 32'h0000_3800);
        wr(A_ST, 32'h0000_0000);
        rd(A_ST, v, vn);
        check("R2 clear status", v, 32'h0000_1800);
    endtask

    task automatic t_enable;
        logic [31:0] v, vn;
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v, vn);
        check("R5 enable all-ones", v, 32'hFFFF_0888);
        wr(A_EN, 32'h0000_F777);
        rd(A_EN, v, vn);
        check("R5 enable fixed-zero bits", v, 32'h0);
    endtask

    task automatic t_pending;
        logic [31:0] v, vn;
        @(negedge clk);
        irq = 32'hFFFF_FFFF;
        rd(A_PD, v, vn);
        check("R6 pending before edge", v, 32'h0);
        @(posedge clk);
        #1;
        check("R6 pending after edge", rdata, 32'hFFFF_0888);
        wr(A_PD, 32'h0);
        rd(A_PD, v, vn);
        check("R6 pending ignores write", v, 32'hFFFF_0888);
        @(negedge clk);
        irq = 32'h0;
        @(negedge clk);
    endtask

    task automatic t_irq_req;
        wr(A_EN, 32'h0000_0080);
        wr(A_ST, 32'h0000_0008);
        @(negedge clk);
        irq = 32'h0000_0008;
        @(negedge clk);
        check("R9 pending not enabled", {31'd0, req}, 32'h0);
        irq = 32'h0000_0080;
        @(negedge clk);
        check("R9 pending and enabled", {31'd0, req}, 32'h1);
        wr(A_ST, 32'h0);
        check("R9 gie low masks", {31'd0, req}, 32'h0);
        irq = 32'h0;
        wr(A_EN, 32'h0);
    endtask

    task automatic t_trap;
        logic [31:0] v, vn;
        wr(A_ST, 32'h0000_0008);
        pulse(1'b1, 1'b0);
        rd(A_ST, v, vn);
        check("R7 entry saves 1", v, 32'h0000_1880);
        pulse(1'b0, 1'b1);
        rd(A_ST, v, vn);
        check("R8 return restores 1", v, 32'h0000_1888);
        wr(A_ST, 32'h0);
        rd(A_ST, v, vn);
        check("R2 write keeps bit7", v, 32'h0000_1880);
        pulse(1'b1, 1'b0);
        rd(A_ST, v, vn);
        check("R7 entry saves 0", v, 32'h0000_1800);
        pulse(1'b0, 1'b1);
        rd(A_ST, v, vn);
        check("R8 return sets bit7", v, 32'h0000_1880);
    endtask

    task automatic t_collision;
        logic [31:0] v, vn;
        wr(A_ST, 32'h0000_0008);
        @(negedge clk);
        addr = A_ST; wdata = 32'h0000_6008; we = 1'b1; tenter = 1'b1;
        @(negedge clk);
        we = 1'b0; tenter = 1'b0;
        rd(A_ST, v, vn);
        check("R10 entry beats write", v, 32'h0000_1880);
        @(negedge clk);
        addr = A_ST; wdata = 32'h0000_6000; we = 1'b1; tret = 1'b1;
        @(negedge clk);
        we = 1'b0; tret = 1'b0;
        rd(A_ST, v, vn);
        check("R10 return beats write", v, 32'h0000_1888);
    endtask

    task automatic t_unmapped;
        logic [31:0] v, vn;
        wr(12'h305, 32'hFFFF_FFFF);
        rd(12'h305, v, vn);
        check("R11 unmapped reads zero", v, 32'h0);
        rd(A_ST, v, vn);
        check("R11 status untouched", v, 32'h0000_1888);
        rd(A_EN, v, vn);
        check("R11 enable untouched", v, 32'h0);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_write();
        t_enable();
        t_pending();
        t_irq_req();
        t_trap();
        t_collision();
        t_unmapped();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

endmodule